// File: doc/BRIEF.md
# Memory and Bus Error Capture Unit

This block sits beside a memory controller and watches each transfer it runs, whether to main memory or to the secondary cache. It makes byte-lane parity for every write it issues. When checking is enabled, it checks parity on read data beats. Memory transfers whose address lies outside a configured window are select errors. For these the row strobe is held off, write data is dropped, and a read completes at once with undefined data. Every error is recorded in sticky status registers. The first error also freezes the address of the transfer that caused it.

The response to an error depends on who started the transfer. A read error seen by a bus master that has parity response enabled ends in a target-abort. A read error seen by the processor, or by a bus master with that response off, only sets the status, and the transfer ends normally. An error from a bus-master transfer also sets a separate bus-origin flag. If a non-maskable condition is present when the error is logged, the address is not captured and an "address invalid" flag is raised instead. Software reads the status through a small register port and clears the flags by writing ones to them.

The transfer sequencer has four states:
- IDLE: takes a request when `txn_valid` is high and moves to ACCESS.
- ACCESS: a write always stays one cycle. A select error also stays one cycle. A read waits for `rd_valid`. The state then goes to ABORT when a read error hits a bus master with response enabled, and to DONE in every other case.
- DONE and ABORT: each lasts one cycle and returns to IDLE.

Top module: `err_capture_unit`

## Requirements
- R1: After reset, all status and address registers read zero, `txn_ready` is 1, and `ras_en`, `wr_discard`, `txn_done` and `target_abort` are 0.
- R2: `wr_par` bit i is the parity of data byte i, so that the 9-bit group has even parity, or odd parity when PAR_ODD=1. Parity presented on `rd_par` while a write is in ACCESS is never checked and sets no flag.
- R3: With `mem_par_en`=1, a memory read beat whose `rd_par` differs from the parity generated from `rd_data` sets bit 2 of status register 1 (reg_sel=0). With `mem_par_en`=0, the same beat sets nothing.
- R4: A memory access with address below `mem_base` or above `mem_limit` sets bit 5 of status register 1. During its ACCESS cycle `ras_en` stays 0. A write has `wr_discard`=1. A read completes without waiting for `rd_valid`.
- R5: With `cache_par_en`=1, a cache read beat with bad parity sets bit 4 of status register 2 (reg_sel=1). With it at 0, the same beat sets nothing. Cache accesses are never range-checked.
- R6: A read error on a transfer with `txn_pci`=1 and `pci_perr_resp`=1 ends with a one-cycle `target_abort` and no `txn_done`. Every other transfer ends with a one-cycle `txn_done`.
- R7: Any error on a transfer with `txn_pci`=1 sets bit 3 of status register 1, whatever the value of `pci_perr_resp`.
- R8: The first error, logged while no error flag (reg1 bits 2, 3, 5, reg2 bit 4) is set, captures the transfer address into reg_sel=2 and clears reg2 bit 7. Later errors leave the address unchanged until those flags are cleared.
- R9: An error logged while `nmi_req`=1 and no flag is set sets reg2 bit 7 and leaves the address register unchanged.
- R10: A write on the register port with `reg_wr`=1 clears each status bit of the selected register (reg_sel 0 or 1) whose `reg_wdata` bit is 1. Other bits are kept.
- R11: `txn_ready` is 1 only in IDLE. Each request passes through ACCESS and exactly one of DONE or ABORT, and the unit then returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_par_en | input | 1 | Enable memory read parity check |
| cache_par_en | input | 1 | Enable cache read parity check |
| pci_perr_resp | input | 1 | Bus-master parity response enable |
| mem_base | input | AW | Lowest populated memory address |
| mem_limit | input | AW | Highest populated memory address |
| nmi_req | input | 1 | Non-maskable condition; blocks address capture |
| txn_valid | input | 1 | Transfer request |
| txn_ready | output | 1 | Unit idle, request accepted |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_cache | input | 1 | 1 = secondary cache, 0 = main memory |
| txn_pci | input | 1 | 1 = bus master initiator, 0 = processor |
| txn_addr | input | AW | Transfer address |
| wr_data | input | DW | Write data |
| wr_par | output | DW/8 | Generated write parity |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | DW | Read data |
| rd_par | input | DW/8 | Read parity |
| ras_en | output | 1 | Row strobe enable for memory access |
| wr_discard | output | 1 | Write data dropped |
| txn_done | output | 1 | Normal completion pulse |
| target_abort | output | 1 | Target-abort pulse |
| reg_sel | input | 2 | 0 = status 1, 1 = status 2, 2 = error address |
| reg_wr | input | 1 | Write-one-to-clear strobe |
| reg_wdata | input | 8 | Clear mask |
| reg_rdata | output | AW | Selected register value |

## Verification
The bench builds the unit with a 32-bit data path (four parity lanes), a 16-bit address and odd parity sense. Odd sense flips every generated and checked parity bit, so an inverted parity sense is caught. The short address lets the memory window sit in the middle of the space, which puts addresses both below the base and above the limit within reach. A behavioural model predicts the outputs and every register value on each clock. The scenarios cover both initiators, both response settings, parity enabled and disabled, a frozen address, and capture under a non-maskable condition.

// File: rtl/err_cap_pkg.sv
package err_cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_DONE,
        ST_ABORT
    } txn_state_e;

    localparam int S1_MEM_PAR  = 2;
    localparam int S1_BUS_ORIG = 3;
    localparam int S1_SELECT   = 5;
    localparam int S2_CACHE_PAR = 4;
    localparam int S2_ADDR_BAD  = 7;

    typedef struct packed {
        logic write;
        logic cache;
        logic bus;
        logic sel_err;
    } txn_info_t;

    typedef struct packed {
        logic mem_par;
        logic cache_par;
        logic sel;
        logic bus;
    } err_ev_t;

endpackage

// File: rtl/err_lane_parity.sv
module err_lane_parity #(
    parameter int DW      = 64,
    parameter bit PAR_ODD = 1'b0,
    localparam int LANES  = DW / 8
) (
    input  logic [DW-1:0]    data,
    output logic [LANES-1:0] par
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par[g] = (^data[8*g +: 8]) ^ PAR_ODD;
    end
endmodule

// File: rtl/err_range_check.sv
module err_range_check #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic          outside
);
    always_comb outside = (addr < base) || (addr > limit);
endmodule

// File: rtl/err_txn_fsm.sv
module err_txn_fsm
    import err_cap_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          txn_valid,
    input  logic          txn_write,
    input  logic          txn_cache,
    input  logic          txn_pci,
    input  logic [AW-1:0] txn_addr,
    input  logic          sel_err_in,
    input  logic          rd_valid,
    input  logic          rd_bad,
    input  logic          mem_par_en,
    input  logic          cache_par_en,
    input  logic          pci_perr_resp,
    output logic          txn_ready,
    output logic          ras_en,
    output logic          wr_discard,
    output logic          txn_done,
    output logic          target_abort,
    output err_ev_t       ev,
    output logic          ev_any,
    output logic [AW-1:0] ev_addr
);
    txn_state_e state_q, state_d;
    txn_info_t  info_q;
    logic [AW-1:0] addr_q;
    logic in_acc, beat_bad, read_err, abort_now, leave_acc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info_q <= '0;
            addr_q <= '0;
        end else if (state_q == ST_IDLE && txn_valid) begin
            info_q <= '{write: txn_write, cache: txn_cache, bus: txn_pci, sel_err: sel_err_in};
            addr_q <= txn_addr;
        end
    end

    // error events
    always_comb begin
        in_acc       = (state_q == ST_ACCESS);
        beat_bad     = in_acc && !info_q.write && !info_q.sel_err && rd_valid && rd_bad;
        ev.sel       = in_acc && info_q.sel_err;
        ev.mem_par   = beat_bad && !info_q.cache && mem_par_en;
        ev.cache_par = beat_bad && info_q.cache && cache_par_en;
        ev_any       = ev.sel || ev.mem_par || ev.cache_par;
        ev.bus       = ev_any && info_q.bus;
        read_err     = !info_q.write && ev_any;
        abort_now    = read_err && info_q.bus && pci_perr_resp;
        leave_acc    = info_q.write || info_q.sel_err || rd_valid;
        ev_addr      = addr_q;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (txn_valid) state_d = ST_ACCESS;
            ST_ACCESS: if (leave_acc) state_d = abort_now ? ST_ABORT : ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_ABORT:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        txn_ready    = 1'b0;
        ras_en       = 1'b0;
        wr_discard   = 1'b0;
        txn_done     = 1'b0;
        target_abort = 1'b0;
        unique case (state_q)
            ST_IDLE:   txn_ready = 1'b1;
            ST_ACCESS: begin
                ras_en     = !info_q.cache && !info_q.sel_err;
                wr_discard = info_q.write && info_q.sel_err;
            end
            ST_DONE:   txn_done = 1'b1;
            ST_ABORT:  target_abort = 1'b1;
        endcase
    end
endmodule

// File: rtl/err_status_regs.sv
module err_status_regs
    import err_cap_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  err_ev_t       ev,
    input  logic          ev_any,
    input  logic          nmi_req,
    input  logic [AW-1:0] ev_addr,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic [7:0]    det1_q,
    output logic [7:0]    det2_q,
    output logic [AW-1:0] eaddr_q,
    output logic          addr_locked
);
    logic [7:0] clr1, clr2, set1, set2, drop2;
    logic capture;

    always_comb begin
        addr_locked = det1_q[S1_MEM_PAR] || det1_q[S1_BUS_ORIG] ||
                      det1_q[S1_SELECT]  || det2_q[S2_CACHE_PAR];
        capture = ev_any && !addr_locked;
        clr1 = (reg_wr && reg_sel == 2'd0) ? reg_wdata : 8'h00;
        clr2 = (reg_wr && reg_sel == 2'd1) ? reg_wdata : 8'h00;
        set1 = 8'h00;
        set1[S1_MEM_PAR]  = ev.mem_par;
        set1[S1_BUS_ORIG] = ev.bus;
        set1[S1_SELECT]   = ev.sel;
        set2 = 8'h00;
        set2[S2_CACHE_PAR] = ev.cache_par;
        set2[S2_ADDR_BAD]  = capture && nmi_req;
        drop2 = 8'h00;
        drop2[S2_ADDR_BAD] = capture && !nmi_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det1_q  <= '0;
            det2_q  <= '0;
            eaddr_q <= '0;
        end else begin
            det1_q <= (det1_q & ~clr1) | set1;
            det2_q <= ((det2_q & ~clr2) | set2) & ~drop2;
            if (capture && !nmi_req) eaddr_q <= ev_addr;
        end
    end

    always_comb begin
        unique case (reg_sel)
            2'd0:    reg_rdata = {{(AW-8){1'b0}}, det1_q};
            2'd1:    reg_rdata = {{(AW-8){1'b0}}, det2_q};
            2'd2:    reg_rdata = eaddr_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/err_capture_unit.sv
module err_capture_unit
    import err_cap_pkg::*;
#(
    parameter int DW      = 64,
    parameter int AW      = 32,
    parameter bit PAR_ODD = 1'b0,
    localparam int LANES  = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_par_en,
    input  logic             cache_par_en,
    input  logic             pci_perr_resp,
    input  logic [AW-1:0]    mem_base,
    input  logic [AW-1:0]    mem_limit,
    input  logic             nmi_req,
    input  logic             txn_valid,
    output logic             txn_ready,
    input  logic             txn_write,
    input  logic             txn_cache,
    input  logic             txn_pci,
    input  logic [AW-1:0]    txn_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [LANES-1:0] wr_par,
    input  logic             rd_valid,
    input  logic [DW-1:0]    rd_data,
    input  logic [LANES-1:0] rd_par,
    output logic             ras_en,
    output logic             wr_discard,
    output logic             txn_done,
    output logic             target_abort,
    input  logic [1:0]       reg_sel,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [AW-1:0]    reg_rdata
);
    logic [LANES-1:0] rd_gen;
    logic             outside, sel_err_in, rd_bad, ev_any, addr_locked;
    err_ev_t          ev;
    logic [AW-1:0]    ev_addr, eaddr_q;
    logic [7:0]       det1_q, det2_q;

    err_lane_parity #(.DW(DW), .PAR_ODD(PAR_ODD)) u_wpar (.data(wr_data), .par(wr_par));
    err_lane_parity #(.DW(DW), .PAR_ODD(PAR_ODD)) u_rpar (.data(rd_data), .par(rd_gen));

    err_range_check #(.AW(AW)) u_range (
        .addr(txn_addr), .base(mem_base), .limit(mem_limit), .outside(outside)
    );

    always_comb begin
        sel_err_in = !txn_cache && outside;
        rd_bad     = (rd_gen != rd_par);
    end

    err_txn_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_write(txn_write),
        .txn_cache(txn_cache), .txn_pci(txn_pci), .txn_addr(txn_addr),
        .sel_err_in(sel_err_in), .rd_valid(rd_valid), .rd_bad(rd_bad),
        .mem_par_en(mem_par_en), .cache_par_en(cache_par_en),
        .pci_perr_resp(pci_perr_resp), .txn_ready(txn_ready), .ras_en(ras_en),
        .wr_discard(wr_discard), .txn_done(txn_done), .target_abort(target_abort),
        .ev(ev), .ev_any(ev_any), .ev_addr(ev_addr)
    );

    err_status_regs #(.AW(AW)) u_stat (
        .clk(clk), .rst_n(rst_n), .ev(ev), .ev_any(ev_any), .nmi_req(nmi_req),
        .ev_addr(ev_addr), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .det1_q(det1_q), .det2_q(det2_q), .eaddr_q(eaddr_q),
        .addr_locked(addr_locked)
    );
endmodule

// File: rtl/err_capture_unit_chk.sv
module err_capture_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          txn_ready,
    input logic          ras_en,
    input logic          wr_discard,
    input logic          txn_done,
    input logic          target_abort,
    input logic          pci_perr_resp,
    input logic          reg_wr,
    input logic [1:0]    reg_sel,
    input logic [7:0]    reg_wdata,
    input logic [7:0]    det1_q,
    input logic [AW-1:0] eaddr_q,
    input logic          addr_locked
);
    a_r4_no_row_on_discard: assert property (@(posedge clk) disable iff (!rst_n)
        wr_discard |-> !ras_en);

    a_r6_single_ending: assert property (@(posedge clk) disable iff (!rst_n)
        !(txn_done && target_abort));

    a_r6_abort_needs_resp: assert property (@(posedge clk) disable iff (!rst_n)
        target_abort |-> pci_perr_resp);

    a_r11_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done || target_abort) |=> txn_ready);

    a_r11_row_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ras_en |-> !txn_ready);

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (det1_q[2] && !(reg_wr && reg_sel == 2'd0 && reg_wdata[2])) |=> det1_q[2]);

    a_r8_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_locked && !reg_wr) |=> $stable(eaddr_q));
endmodule

bind err_capture_unit err_capture_unit_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .txn_ready(txn_ready), .ras_en(ras_en),
    .wr_discard(wr_discard), .txn_done(txn_done), .target_abort(target_abort),
    .pci_perr_resp(pci_perr_resp), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .det1_q(det1_q), .eaddr_q(eaddr_q),
    .addr_locked(addr_locked)
);

// File: tb/err_capture_unit_tb_top.sv
`timescale 1ns/100ps
module err_capture_unit_tb_top;
    localparam int DW = 32;
    localparam int AW = 16;
    localparam bit ODD = 1'b1;
    localparam int LN = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mem_par_en = 1'b0, cache_par_en = 1'b0, pci_perr_resp = 1'b0, nmi_req = 1'b0;
    logic [AW-1:0] mem_base = 16'h0100, mem_limit = 16'h0FFF;
    logic txn_valid = 1'b0, txn_write = 1'b0, txn_cache = 1'b0, txn_pci = 1'b0;
    logic [AW-1:0] txn_addr = '0;
    logic [DW-1:0] wr_data = '0, rd_data = '0;
    logic [LN-1:0] rd_par = '0, wr_par;
    logic rd_valid = 1'b0;
    logic txn_ready, ras_en, wr_discard, txn_done, target_abort;
    logic [1:0] reg_sel = 2'd0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;

    integer checks = 0, fails = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    err_capture_unit #(.DW(DW), .AW(AW), .PAR_ODD(ODD)) dut_i (.*);

    function automatic logic [LN-1:0] lanepar(input logic [DW-1:0] d);
        logic [LN-1:0] p;
        for (int i = 0; i < LN; i++) p[i] = (^d[8*i +: 8]) ^ ODD;
        return p;
    endfunction

    task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_ph = 0;
    logic m_w = 0, m_c = 0, m_p = 0, m_s = 0;
    logic [AW-1:0] m_a = '0, m_eaddr = '0;
    logic [7:0] m_d1 = '0, m_d2 = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_d1 = '0; m_d2 = '0; m_eaddr = '0;
            m_w = 0; m_c = 0; m_p = 0; m_s = 0; m_a = '0;
        end else begin
            logic e_mp, e_cp, e_sel, any, locked;
            int nxt;
            e_mp = 0; e_cp = 0; e_sel = 0; nxt = m_ph;
            case (m_ph)
                0: if (txn_valid) begin
                    m_w = txn_write; m_c = txn_cache; m_p = txn_pci; m_a = txn_addr;
                    m_s = !txn_cache && (txn_addr < mem_base || txn_addr > mem_limit);
                    nxt = 1;
                end
                1: begin
                    if (m_s) e_sel = 1;
                    else if (!m_w && rd_valid && lanepar(rd_data) != rd_par) begin
                        if (m_c) e_cp = cache_par_en;
                        else     e_mp = mem_par_en;
                    end
                    if (m_w || m_s || rd_valid)
                        nxt = (!m_w && (e_sel || e_mp || e_cp) && m_p && pci_perr_resp) ? 3 : 2;
                end
                default: nxt = 0;
            endcase
            any = e_sel | e_mp | e_cp;
            locked = m_d1[2] | m_d1[3] | m_d1[5] | m_d2[4];
            if (reg_wr && reg_sel == 2'd0) m_d1 = m_d1 & ~reg_wdata;
            if (reg_wr && reg_sel == 2'd1) m_d2 = m_d2 & ~reg_wdata;
            if (e_mp) m_d1[2] = 1;
            if (e_sel) m_d1[5] = 1;
            if (any && m_p) m_d1[3] = 1;
            if (e_cp) m_d2[4] = 1;
            if (any && !locked) begin
                if (nmi_req) m_d2[7] = 1;
                else begin m_d2[7] = 0; m_eaddr = m_a; end
            end
            m_ph = nxt;
        end
    end

    always @(negedge clk) begin
        if (rst_n && started) begin
            logic [AW-1:0] er;
            cmp(32'(txn_ready), 32'(m_ph == 0), "R11 txn_ready");
            cmp(32'(ras_en), 32'(m_ph == 1 && !m_c && !m_s), "R4 ras_en");
            cmp(32'(wr_discard), 32'(m_ph == 1 && m_w && m_s), "R4 wr_discard");
            cmp(32'(txn_done), 32'(m_ph == 2), "R6 txn_done");
            cmp(32'(target_abort), 32'(m_ph == 3), "R6 target_abort");
            cmp(32'(wr_par), 32'(lanepar(wr_data)), "R2 wr_par");
            case (reg_sel)
                2'd0: er = {8'h00, m_d1};
                2'd1: er = {8'h00, m_d2};
                2'd2: er = m_eaddr;
                default: er = '0;
            endcase
            cmp(32'(reg_rdata), 32'(er), "R7 R5 R8 reg_rdata");
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic expect_reg(input logic [1:0] s, input logic [AW-1:0] exp, input string what);
        reg_sel = s;
        @(negedge clk);
        cmp(32'(reg_rdata), 32'(exp), what);
        tick();
    endtask

    task automatic clr(input logic [1:0] s, input logic [7:0] m);
        reg_sel = s; reg_wr = 1; reg_wdata = m;
        tick();
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic do_rd(input logic c, input logic p, input logic [AW-1:0] a,
                         input logic bad, input int lat);
        logic [DW-1:0] d;
        d = {a ^ 16'h3C5A, a};
        txn_valid = 1; txn_write = 0; txn_cache = c; txn_pci = p; txn_addr = a;
        tick();
        txn_valid = 0;
        for (int i = 0; i < lat; i++) tick();
        rd_valid = 1; rd_data = d; rd_par = lanepar(d) ^ {{(LN-1){1'b0}}, bad};
        tick();
        rd_valid = 0;
        for (int i = 0; i < 3; i++) tick();
    endtask

    task automatic do_wr(input logic p, input logic [AW-1:0] a, input logic [DW-1:0] d);
        txn_valid = 1; txn_write = 1; txn_cache = 0; txn_pci = p; txn_addr = a; wr_data = d;
        tick();
        txn_valid = 0;
        rd_valid = 1; rd_data = ~d; rd_par = ~lanepar(~d);   // bad parity during a write
        tick();
        rd_valid = 0;
        for (int i = 0; i < 3; i++) tick();
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL R11 watchdog expired: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) @(posedge clk);
        #1 rst_n = 1;
        started = 1;
        // R1 reset state
        @(negedge clk);
        cmp(32'(txn_ready), 32'd1, "R1 ready after reset");
        cmp(32'({ras_en, wr_discard, txn_done, target_abort}), 32'd0, "R1 strobes after reset");
        tick();
        expect_reg(2'd0, 16'h0000, "R1 status1 reset");
        expect_reg(2'd1, 16'h0000, "R1 status2 reset");
        expect_reg(2'd2, 16'h0000, "R1 address reset");

        // R2 write parity generated, write beat not checked
        mem_par_en = 1;
        do_wr(0, 16'h0200, 32'hA5C3_0F01);
        do_wr(0, 16'h0210, 32'hFFFF_0000);
        expect_reg(2'd0, 16'h0000, "R2 no flag from write");

        // R3 good read, disabled check, enabled bad read
        do_rd(0, 0, 16'h0300, 0, 1);
        mem_par_en = 0;
        do_rd(0, 0, 16'h0310, 1, 0);
        expect_reg(2'd0, 16'h0000, "R3 check disabled");
        mem_par_en = 1;
        do_rd(0, 0, 16'h0400, 1, 2);
        expect_reg(2'd0, 16'h0004, "R3 parity flag");
        expect_reg(2'd2, 16'h0400, "R8 first address");
        // R8 frozen address
        do_rd(0, 0, 16'h0500, 1, 0);
        expect_reg(2'd2, 16'h0400, "R8 address frozen");
        // R10 clear
        clr(2'd0, 8'hFB);
        expect_reg(2'd0, 16'h0004, "R10 unmasked bit kept");
        clr(2'd0, 8'h04);
        expect_reg(2'd0, 16'h0000, "R10 cleared");

        // R6/R7 bus master, response off
        pci_perr_resp = 0;
        do_rd(0, 1, 16'h0600, 1, 1);
        expect_reg(2'd0, 16'h000C, "R7 bus origin, response off");
        expect_reg(2'd2, 16'h0600, "R8 recapture after clear");
        clr(2'd0, 8'hFF);
        // R6 bus master, response on -> abort
        pci_perr_resp = 1;
        do_rd(0, 1, 16'h0700, 1, 0);
        expect_reg(2'd0, 16'h000C, "R6 abort case flags");
        clr(2'd0, 8'hFF);
        // processor with response on -> normal end
        do_rd(0, 0, 16'h0710, 1, 0);
        clr(2'd0, 8'hFF);

        // R4 select errors
        do_wr(0, 16'h2000, 32'h1234_5678);
        expect_reg(2'd0, 16'h0020, "R4 write above limit");
        expect_reg(2'd2, 16'h2000, "R4 address captured");
        clr(2'd0, 8'hFF);
        do_rd(0, 1, 16'h0080, 0, 2);
        expect_reg(2'd0, 16'h0028, "R4 read below base by bus master");
        clr(2'd0, 8'hFF);
        pci_perr_resp = 0;

        // R5 cache parity
        cache_par_en = 0;
        do_rd(1, 0, 16'h0050, 1, 0);
        expect_reg(2'd1, 16'h0000, "R5 cache check disabled");
        cache_par_en = 1;
        do_rd(1, 0, 16'h0050, 1, 1);
        expect_reg(2'd1, 16'h0010, "R5 cache parity flag");
        expect_reg(2'd2, 16'h0050, "R5 cache address, no range check");
        clr(2'd1, 8'h10);
        expect_reg(2'd1, 16'h0000, "R10 status2 cleared");

        // R9 non-maskable condition
        nmi_req = 1;
        do_rd(0, 0, 16'h0900, 1, 0);
        nmi_req = 0;
        expect_reg(2'd0, 16'h0004, "R9 flag still set");
        expect_reg(2'd1, 16'h0080, "R9 address invalid");
        expect_reg(2'd2, 16'h0050, "R9 address unchanged");
        clr(2'd0, 8'hFF);
        do_rd(0, 0, 16'h0A00, 1, 0);
        expect_reg(2'd1, 16'h0000, "R8 valid capture clears invalid bit");
        expect_reg(2'd2, 16'h0A00, "R8 new address");

        for (int i = 0; i < 4; i++) tick();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule